// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Reset Pulse

This block is a 16-bit down-counting supervisor timer clocked from the peripheral clock. The count advances on a slow tick produced by two dividers in series. The first is a programmable prescaler that divides by (P+1). The second divides the prescaler output by 16, 32, 64 or 128. Software loads a start value into the count register, and in normal operation it must rewrite that register before the count runs out.

When the count runs out, the counter reloads itself from a separate reload register and keeps counting. Depending on the enable bits, expiry can do either or both of two things. It can latch a level interrupt, so the block serves as a periodic interval timer. It can also start a system reset pulse that lasts exactly 128 clock cycles, so the block serves as a watchdog.

Software reaches the block through a simple single-cycle register bus. Writes are taken on the clock edge and reads are combinational.

The address map is:
- 0: control
- 1: reload
- 2: live count
- 3: interrupt clear, which is write-only and reads as zero

The control register fields are:
- bit 0: run enable
- bit 1: interrupt enable
- bit 2: reset enable
- bits 4:3: division select
- bits 7:5: reserved, reading as zero
- bits 15:8: prescale value

Top module: `wdog_timer`

The counter control is a two-state machine. It moves from CT_STOP to CT_RUN on transition T_START when run enable is set. It moves from CT_RUN back to CT_STOP on transition T_HALT when run enable is cleared.

The reset pulse generator is also a two-state machine. It moves from PL_IDLE to PL_ACTIVE on transition T_FIRE, which happens on an expiry while reset enable is set. It moves from PL_ACTIVE back to PL_IDLE on transition T_DONE, after the pulse length has elapsed.

## Requirements
- R1: After reset the registers read as follows: control 0xFF05 (run and reset enabled, prescale 255, division select 0), reload 0x8000 and count 0x8000. The interrupt and reset outputs are low.
- R2: While running, the count drops by one every (P+1)*F clock cycles. P is control bits 15:8, and F is 16 shifted left by control bits 4:3.
- R3: A write to address 2 loads the count on that clock edge, so the value reads back from the next cycle. The write also restarts both divider stages, so the first decrement comes exactly (P+1)*F cycles after the write edge.
- R4: On a tick that finds the count at 1, the block expires and the count takes the value of the reload register (address 1).
- R5: An expiry with interrupt enable (control bit 1) set raises the interrupt output on that edge. The output stays high until software writes to address 3.
- R6: With interrupt enable clear, an expiry leaves the interrupt output low.
- R7: An expiry with reset enable (control bit 2) set drives the reset output high from that edge for exactly 128 cycles. Expiries that occur during the pulse do not lengthen it.
- R8: With reset enable clear, an expiry leaves the reset output low.
- R9: With run enable (control bit 0) clear, the count holds its value. A write to address 2 still loads it.
- R10: A count of 0 is treated like a count of 1: the block expires on the first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq_o | output | 1 | Level interrupt, latched on expiry |
| wdt_rst_o | output | 1 | System reset pulse, active high |

## Verification
The assertions assume that a bus write lasts a single cycle and that the write data is stable in that cycle.

They also assume that the reset pulse follows an expiry that happened while reset enable was already set. Changing the enable in the same cycle as the expiry therefore falls outside what the checks model.

To stay within these assumptions, the stimulus drives every bus access from the falling edge for exactly one cycle. It reprograms the control and reload registers before restarting the count, so the enable bits are always settled well before the next expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W    = 16;
    localparam int PRE_W     = 8;
    localparam int SEL_W     = 2;
    localparam int BASE_LOG2 = 4;
    localparam int ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 2'd3;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic [2:0]       rsv;
        logic [SEL_W-1:0] div_sel;
        logic             rst_en;
        logic             irq_en;
        logic             run_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{prescale: '1, rsv: '0, div_sel: '0,
                                     rst_en: 1'b1, irq_en: 1'b0, run_en: 1'b1};

    typedef enum logic {CT_STOP, CT_RUN} ct_state_t;
    typedef enum logic {PL_IDLE, PL_ACTIVE} pl_state_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RELOAD_INIT = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              irq
);
    logic wr_en;
    assign wr_en    = bus_sel && bus_wr;
    assign load     = wr_en && (bus_addr == A_COUNT);
    assign load_val = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= CTRL_RESET;
            reload <= RELOAD_INIT;
        end else if (wr_en) begin
            if (bus_addr == A_CTRL) begin
                ctrl     <= ctrl_t'(bus_wdata);
                ctrl.rsv <= '0;
            end
            if (bus_addr == A_RELOAD) reload <= bus_wdata[CNT_W-1:0];
        end
    end

    // expiry takes priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  irq <= 1'b0;
        else if (expire && ctrl.irq_en)              irq <= 1'b1;
        else if (wr_en && (bus_addr == A_CLEAR))     irq <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   bus_rdata = DATA_W'(ctrl);
            A_RELOAD: bus_rdata = DATA_W'(reload);
            A_COUNT:  bus_rdata = DATA_W'(cnt);
            A_CLEAR:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_divider.sv
module wdog_divider
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [PRE_W-1:0] prescale,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int DC_W = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [DC_W-1:0]  div_q;
    logic [DC_W-1:0]  div_last;
    logic             pre_tick;

    assign div_last = DC_W'((1 << (BASE_LOG2 + int'(div_sel))) - 1);
    assign pre_tick = enable && (pre_q == prescale);
    assign tick     = pre_tick && (div_q == div_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (enable) begin
            pre_q <= pre_tick ? '0 : pre_q + 1'b1;
            if (pre_tick) div_q <= (div_q >= div_last) ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] CNT_INIT = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             expire
);
    ct_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CT_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_STOP: if (run_en)  state_d = CT_RUN;   // T_START
            CT_RUN:  if (!run_en) state_d = CT_STOP;  // T_HALT
        endcase
    end

    always_comb begin
        active = (state_q == CT_RUN);
        expire = active && tick && !load && (cnt <= CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= CNT_INIT;
        else if (load)             cnt <= load_val;
        else if (expire)           cnt <= reload;
        else if (active && tick)   cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int PC_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    pl_state_t       state_q, state_d;
    logic [PC_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PL_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PL_IDLE && fire) left_q <= PC_W'(PULSE_LEN - 1);
            else if (state_q == PL_ACTIVE)  left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PL_IDLE:   if (fire)          state_d = PL_ACTIVE; // T_FIRE
            PL_ACTIVE: if (left_q == '0)  state_d = PL_IDLE;   // T_DONE
        endcase
    end

    always_comb pulse = (state_q == PL_ACTIVE);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, load_val, cnt;
    logic             load, tick, active, expire;

    wdog_regs #(.CNT_W(CNT_W), .RELOAD_INIT(CNT_INIT)) regs_i (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .cnt, .expire, .ctrl, .reload, .load, .load_val, .irq(irq_o)
    );

    wdog_divider div_i (
        .clk, .rst_n, .enable(active), .restart(load),
        .prescale(ctrl.prescale), .div_sel(ctrl.div_sel), .tick
    );

    wdog_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) cnt_i (
        .clk, .rst_n, .run_en(ctrl.run_en), .tick, .load, .load_val,
        .reload, .cnt, .active, .expire
    );

    wdog_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
        .clk, .rst_n, .fire(expire && ctrl.rst_en), .pulse(wdt_rst_o)
    );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic              wdt_rst_o,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              tick,
    input logic              expire,
    input logic              run_en,
    input logic              irq_en,
    input logic              rst_en
);
    localparam int HI_W = $clog2(PULSE_LEN + 2) + 1;

    logic            cnt_wr, clr_wr;
    logic [HI_W-1:0] hi_q;

    assign cnt_wr = bus_sel && bus_wr && (bus_addr == A_COUNT);
    assign clr_wr = bus_sel && bus_wr && (bus_addr == A_CLEAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_q <= '0;
        else if (wdt_rst_o) hi_q <= hi_q + 1'b1;
        else                hi_q <= '0;
    end

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run_en && $past(run_en) && cnt > CNT_W'(1) && !cnt_wr) |=> (cnt == $past(cnt) - 1'b1)); // R2
    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(bus_wdata[CNT_W-1:0]))); // R3
    AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cnt_wr) |=> (cnt == $past(reload))); // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(expire && irq_en)); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_wr) |=> irq_o); // R5
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> $past(expire && rst_en)); // R8
    AST_RST_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_o) |-> (hi_q == HI_W'(PULSE_LEN))); // R7
    AST_RST_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        hi_q <= HI_W'(PULSE_LEN)); // R7
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && $past(!run_en) && !cnt_wr) |=> $stable(cnt)); // R9
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
    .wdt_rst_o(wdt_rst_o), .cnt(cnt), .reload(reload), .tick(tick),
    .expire(expire), .run_en(ctrl.run_en), .irq_en(ctrl.irq_en),
    .rst_en(ctrl.rst_en)
);

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o, wdt_rst_o;

    int    n_tests = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    logic [15:0] exp_q[$];
    logic [15:0] act_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    wdog_timer dut_i (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
        .bus_rdata, .irq_o, .wdt_rst_o
    );

    // monitor: pops expected/actual pairs and scores them
    always @(posedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            logic [15:0] e, a;
            string t;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (e !== a) begin
                n_fail++;
                $display("FAIL %s actual=0x%04h expected=0x%04h", t, a, e);
            end
        end
    end

    task automatic expect_val(input string tag, input logic [15:0] e, input logic [15:0] a);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        act_q.push_back(a);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset values
        rd(2'd0, v); expect_val("R1 ctrl", 16'hFF05, v);
        rd(2'd1, v); expect_val("R1 reload", 16'h8000, v);
        rd(2'd2, v); expect_val("R1 count", 16'h8000, v);
        expect_val("R1 irq", 16'(0), 16'(irq_o));
        expect_val("R1 rst", 16'(0), 16'(wdt_rst_o));
        cyc(1);

        // R3 / R2: P=0, F=16, run+irq
        wr(2'd0, 16'h0003);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd3);
        rd(2'd2, v); expect_val("R3 load now", 16'd3, v);
        cyc(15); rd(2'd2, v); expect_val("R3 no early tick", 16'd3, v);
        cyc(1);  rd(2'd2, v); expect_val("R2 first tick", 16'd2, v);

        // R2: P=1, F=32 -> 64 cycles per tick
        cyc(1);
        wr(2'd0, 16'h010B);
        wr(2'd2, 16'd10);
        cyc(63); rd(2'd2, v); expect_val("R2 slow hold", 16'd10, v);
        cyc(1);  rd(2'd2, v); expect_val("R2 slow tick", 16'd9, v);

        // R4 / R5: expiry after two ticks
        cyc(1);
        wr(2'd0, 16'h0003);
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'd2);
        cyc(31); rd(2'd2, v); expect_val("R4 before expiry", 16'd1, v);
        expect_val("R5 irq low before", 16'(0), 16'(irq_o));
        cyc(1);  rd(2'd2, v); expect_val("R4 reloaded", 16'd5, v);
        expect_val("R5 irq set", 16'(1), 16'(irq_o));
        cyc(20); expect_val("R5 irq held", 16'(1), 16'(irq_o));
        wr(2'd3, 16'h0000);
        #1 expect_val("R5 irq cleared", 16'(0), 16'(irq_o));

        // R10: count 0 expires on first tick
        cyc(1);
        wr(2'd2, 16'd0);
        cyc(15); expect_val("R10 irq before tick", 16'(0), 16'(irq_o));
        cyc(1);  rd(2'd2, v); expect_val("R10 reload", 16'd5, v);
        expect_val("R10 irq", 16'(1), 16'(irq_o));
        wr(2'd3, 16'h0000);

        // R6: interrupt disabled
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'd1);
        cyc(16); rd(2'd2, v); expect_val("R6 expired", 16'd5, v);
        #1 expect_val("R6 irq stays low", 16'(0), 16'(irq_o));

        // R7: reset pulse length 128
        cyc(1);
        wr(2'd0, 16'h0005);
        wr(2'd2, 16'd1);
        cyc(15); #1 expect_val("R7 rst before", 16'(0), 16'(wdt_rst_o));
        cyc(1);  #1 expect_val("R7 rst start", 16'(1), 16'(wdt_rst_o));
        cyc(127); #1 expect_val("R7 rst last", 16'(1), 16'(wdt_rst_o));
        cyc(1);  #1 expect_val("R7 rst end", 16'(0), 16'(wdt_rst_o));

        // R8: reset disabled
        cyc(1);
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'd1);
        cyc(16); rd(2'd2, v); expect_val("R8 expired", 16'd5, v);
        #1 expect_val("R8 rst low", 16'(0), 16'(wdt_rst_o));
        cyc(4); #1 expect_val("R8 rst still low", 16'(0), 16'(wdt_rst_o));

        // R9: stopped counter holds, still loadable
        cyc(1);
        wr(2'd0, 16'h0000);
        cyc(2);
        wr(2'd2, 16'd7);
        rd(2'd2, v); expect_val("R9 loaded", 16'd7, v);
        cyc(100); rd(2'd2, v); expect_val("R9 held", 16'd7, v);

        cyc(3);
        n_tests += exp_q.size();
        n_fail  += exp_q.size();
        finish_run();
    end
endmodule